// File: doc/BRIEF.md
# Power Switchover Time Stamp Capture

This block records the calendar time at which a device moves from its main supply onto its backup battery, and the time at which it moves back. It watches a clean, synchronous "backup mode active" level. It also receives a live packed-BCD calendar word from the real-time clock. Whenever that level changes, it may latch the calendar word into one of two stamp registers.

The two directions follow different retention rules:

- **Power-down stamp (main to battery).** Once this stamp is taken, it is frozen. It stays frozen through any further outages until software issues a clear command, so the stored value is always the earliest outage since the last clear.
- **Power-up stamp (battery to main).** This stamp is overwritten on every return to main power, so it always holds the latest event.

Each stamp has a valid flag. Software reads both stamps and the flags through a small address-selected read port.

Top module: `pss_top`

## Requirements
- R1: A 0-to-1 change of `backup_i`, sampled at a clock edge, is a power-down event. When the power-down valid flag is clear, that event stores `cal_time_i` into the power-down stamp and sets the flag. Both are visible from the following cycle.
- R2: A 1-to-0 change of `backup_i` is a power-up event. Every such event stores `cal_time_i` into the power-up stamp and sets its valid flag. An earlier value is always replaced.
- R3: While the power-down valid flag is set and no clear is given, later power-down events leave the power-down stamp unchanged.
- R4: A one-cycle `clear_i` pulse without a power-down event in the same cycle sets the power-down stamp to all zeros and clears its flag. The next power-down event is then captured.
- R5: When `clear_i` and a power-down event fall in the same cycle, the capture takes effect. The stamp takes `cal_time_i` and the flag stays set.
- R6: `clear_i` has no effect on the power-up stamp or its flag.
- R7: A level of `backup_i` held steady for many cycles causes no further capture. A stamp changes only in the cycle after an edge.
- R8: After reset, both stamps read zero and both flags are clear.
- R9: Read port decode on `rd_addr_i`:
  - 0 returns the power-down stamp.
  - 1 returns the power-up stamp.
  - 2 returns status, with bit 0 the power-down flag, bit 1 the power-up flag, and the other bits zero.
  - 3 returns zero.
- R10: The calendar word is 48 bits, captured whole in one cycle. Its byte lanes are seconds [7:0], minutes [15:8], hours [23:16], date [31:24], month [39:32] and year [47:40].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| backup_i | input | 1 | High while running from the backup battery |
| clear_i | input | 1 | One-cycle command that empties the power-down stamp |
| cal_time_i | input | 48 | Live packed-BCD calendar word |
| rd_addr_i | input | 2 | Read register select |
| rd_data_o | output | 48 | Selected register contents |

## Verification
The capture logic is tried with four kinds of input:

- **A single outage followed by recovery.** This shows that each stamp takes the calendar word present at its own edge and not at a neighbouring cycle.
- **Repeated outages with distinct time words.** This separates keep-earliest behaviour on the power-down side from keep-latest behaviour on the power-up side.
- **A clear alone, then a clear landing exactly on a power-down edge.** This distinguishes the clear path from the capture-priority path.
- **Long steady levels between edges.** These show that a held level is not mistaken for an event.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] hour;
        logic [7:0] minute;
        logic [7:0] second;
    } cal_time_t;

    localparam int TW = $bits(cal_time_t);
    localparam int AW = 2;

    typedef enum logic [AW-1:0] {
        RD_DOWN   = 2'd0,
        RD_UP     = 2'd1,
        RD_STATUS = 2'd2,
        RD_NONE   = 2'd3
    } rd_sel_e;

endpackage

// File: rtl/pss_edge_detect.sv
module pss_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic level;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.level = level_i;
        rise_o     = level_i & ~st_q.level;
        fall_o     = ~level_i & st_q.level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: an edge is reported once; a held level reports nothing next cycle
    a_r7_rise_once: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o && level_i |=> !rise_o);
    a_r7_fall_once: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o && !level_i |=> !fall_o);

endmodule

// File: rtl/pss_stamp_reg.sv
module pss_stamp_reg #(
    parameter int TW         = 48,
    parameter bit KEEP_FIRST = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_i,
    input  logic          clr_i,
    input  logic [TW-1:0] time_i,
    output logic [TW-1:0] stamp_o,
    output logic          valid_o
);
    typedef struct packed {
        logic [TW-1:0] stamp;
        logic          valid;
    } stamp_state_t;

    stamp_state_t st_d, st_q;
    logic         cap_en;

    generate
        if (KEEP_FIRST) begin : g_keep_first
            // frozen once valid, unless a clear arrives in the same cycle
            assign cap_en = evt_i && (!st_q.valid || clr_i);
        end else begin : g_keep_last
            assign cap_en = evt_i;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (cap_en) begin
            st_d.stamp = time_i;
            st_d.valid = 1'b1;
        end else if (clr_i) begin
            st_d.stamp = '0;
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stamp_o = st_q.stamp;
    assign valid_o = st_q.valid;

    // R1/R2/R10: a capture latches the whole word of the event cycle
    a_r10_whole_word: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (stamp_o == $past(time_i)) && valid_o);
    // R4: clear without event empties the register
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !evt_i |=> (stamp_o == '0) && !valid_o);
    // R5: clear and event together leave the flag set
    a_r5_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && evt_i |=> valid_o);
    // R7: no event and no clear means no change
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_i && !clr_i |=> $stable(stamp_o) && $stable(valid_o));

    generate
        if (KEEP_FIRST) begin : g_chk_first
            // R3: stored earliest value survives later events
            a_r3_keep_earliest: assert property (@(posedge clk) disable iff (!rst_n)
                valid_o && !clr_i |=> $stable(stamp_o) && valid_o);
        end else begin : g_chk_last
            // R2: every event replaces the value
            a_r2_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
                evt_i |=> stamp_o == $past(time_i));
        end
    endgenerate

endmodule

// File: rtl/pss_read_mux.sv
module pss_read_mux
    import pss_pkg::*;
(
    input  logic [AW-1:0] rd_addr_i,
    input  logic [TW-1:0] down_stamp_i,
    input  logic [TW-1:0] up_stamp_i,
    input  logic          down_valid_i,
    input  logic          up_valid_i,
    output logic [TW-1:0] rd_data_o
);
    always_comb begin
        rd_data_o = '0;
        case (rd_sel_e'(rd_addr_i))
            RD_DOWN:   rd_data_o = down_stamp_i;
            RD_UP:     rd_data_o = up_stamp_i;
            RD_STATUS: rd_data_o = {{(TW-2){1'b0}}, up_valid_i, down_valid_i};
            default:   rd_data_o = '0;
        endcase
    end

    // R9: the unused address always reads zero
    a_r9_empty_addr: assert final (rd_addr_i != 2'd3 || rd_data_o == '0);

endmodule

// File: rtl/pss_top.sv
module pss_top
    import pss_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          backup_i,
    input  logic          clear_i,
    input  logic [TW-1:0] cal_time_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [TW-1:0] rd_data_o
);
    logic          down_evt, up_evt;
    logic [TW-1:0] down_stamp, up_stamp;
    logic          down_vld, up_vld;

    pss_edge_detect u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (backup_i),
        .rise_o  (down_evt),
        .fall_o  (up_evt)
    );

    pss_stamp_reg #(.TW(TW), .KEEP_FIRST(1'b1)) u_down (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (down_evt),
        .clr_i   (clear_i),
        .time_i  (cal_time_i),
        .stamp_o (down_stamp),
        .valid_o (down_vld)
    );

    pss_stamp_reg #(.TW(TW), .KEEP_FIRST(1'b0)) u_up (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (up_evt),
        .clr_i   (1'b0),
        .time_i  (cal_time_i),
        .stamp_o (up_stamp),
        .valid_o (up_vld)
    );

    pss_read_mux u_rd (
        .rd_addr_i    (rd_addr_i),
        .down_stamp_i (down_stamp),
        .up_stamp_i   (up_stamp),
        .down_valid_i (down_vld),
        .up_valid_i   (up_vld),
        .rd_data_o    (rd_data_o)
    );

    // R6: a clear never disturbs the power-up record
    a_r6_clear_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i && !up_evt |=> $stable(up_stamp) && $stable(up_vld));
    // R1: a power-down edge with an empty record sets the flag
    a_r1_first_down: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(backup_i) && !down_vld |=> down_vld && down_stamp == $past(cal_time_i));
    // R2: the power-up flag never drops once set
    a_r2_up_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        up_vld |=> up_vld);

endmodule

// File: tb/tb_pss_top.sv
module tb_pss_top;
    import pss_pkg::*;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          backup_i = 1'b0;
    logic          clear_i = 1'b0;
    logic [TW-1:0] cal_time_i = '0;
    logic [AW-1:0] rd_addr_i = '0;
    logic [TW-1:0] rd_data_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    pss_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .backup_i   (backup_i),
        .clear_i    (clear_i),
        .cal_time_i (cal_time_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [TW-1:0] got, input logic [TW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [TW-1:0] v);
        rd_addr_i = a;
        #1;
        v = rd_data_o;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [TW-1:0] mk(input logic [7:0] y, input logic [7:0] s);
        return {y, 8'h06, 8'h15, 8'h12, 8'h34, s};
    endfunction

    task automatic expect_all(input string req, input logic [TW-1:0] dn,
                              input logic [TW-1:0] up, input logic [1:0] st);
        logic [TW-1:0] v;
        rd(2'd0, v); check({req, " down"}, v, dn);
        rd(2'd1, v); check({req, " up"}, v, up);
        rd(2'd2, v); check({req, " status"}, v, {{(TW-2){1'b0}}, st});
    endtask

    // R8 / R9: reset values and empty address
    task automatic t_reset();
        logic [TW-1:0] v;
        expect_all("R8", '0, '0, 2'b00);
        rd(2'd3, v); check("R9 addr3", v, '0);
    endtask

    // R1 / R10 / R2: one outage, then recovery
    task automatic t_single();
        cal_time_i = mk(8'h24, 8'h11);
        backup_i = 1'b1;
        step();
        cal_time_i = mk(8'h24, 8'h12);
        expect_all("R1", mk(8'h24, 8'h11), '0, 2'b01);
        repeat (5) step();
        // R7: held level, no recapture
        cal_time_i = mk(8'h24, 8'h20);
        backup_i = 1'b0;
        step();
        cal_time_i = mk(8'h24, 8'h21);
        expect_all("R2", mk(8'h24, 8'h11), mk(8'h24, 8'h20), 2'b11);
        repeat (6) step();
        expect_all("R7", mk(8'h24, 8'h11), mk(8'h24, 8'h20), 2'b11);
    endtask

    // R3 / R2: repeated outages keep first down, latest up
    task automatic t_repeat();
        for (int i = 0; i < 3; i++) begin
            cal_time_i = mk(8'h25, 8'(8'h30 + i));
            backup_i = 1'b1;
            step();
            repeat (2) step();
            cal_time_i = mk(8'h25, 8'(8'h40 + i));
            backup_i = 1'b0;
            step();
            repeat (2) step();
        end
        expect_all("R3", mk(8'h24, 8'h11), mk(8'h25, 8'h42), 2'b11);
    endtask

    // R4 / R6: clear alone, then a new capture
    task automatic t_clear();
        clear_i = 1'b1;
        step();
        clear_i = 1'b0;
        expect_all("R4 R6", '0, mk(8'h25, 8'h42), 2'b10);
        cal_time_i = mk(8'h26, 8'h55);
        backup_i = 1'b1;
        step();
        expect_all("R4 recapture", mk(8'h26, 8'h55), mk(8'h25, 8'h42), 2'b11);
        backup_i = 1'b0;
        cal_time_i = mk(8'h26, 8'h56);
        step();
        repeat (2) step();
    endtask

    // R5: clear coincides with a power-down edge while a stamp is held
    task automatic t_clear_edge();
        cal_time_i = mk(8'h27, 8'h07);
        backup_i = 1'b1;
        clear_i = 1'b1;
        step();
        clear_i = 1'b0;
        expect_all("R5", mk(8'h27, 8'h07), mk(8'h26, 8'h56), 2'b11);
        backup_i = 1'b0;
        cal_time_i = mk(8'h27, 8'h08);
        step();
        expect_all("R5 after", mk(8'h27, 8'h07), mk(8'h27, 8'h08), 2'b11);
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_single();
        t_repeat();
        t_clear();
        t_clear_edge();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule